// File: doc/BRIEF.md
# Shared Memory Port Arbiter for a Five-Stage Pipeline

This block decides, cycle by cycle, who owns the one memory port of a five-stage in-order pipeline: the instruction fetch or a data access in the execute stage. Fetch owns the port by default. In that case the address comes from the program counter, a read is enabled, and the program counter advances.

A store that leaves the register-read stage is seen one cycle early. The arbiter registers that fact, and in the next cycle, while the store sits in the execute stage, it hands the port to the data side:
- the address comes from the store's address operand;
- the write enable and the write data come from the store;
- the program-counter update is withheld;
- the fetch/decode instruction register is told to take a bubble.

The later stages keep advancing, so the store completes and leaves the execute stage.

A build-time option gives loads the same treatment, with a read instead of a write. A flush from a taken branch cancels any access that was scheduled for the instruction it squashes.

Top module: `mem_port_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the port is in fetch mode: `addr_sel_data`=0, `mem_rd_en`=1, `mem_wr_en`=0, `pc_we`=1, `fd_bubble`=0, `mem_addr`=`pc`, `mem_wdata`=0.
- R2: When `rf_issue`=1 with `rf_op`=2'b10 (store) and `flush`=0, the next cycle drives `mem_wr_en`=1, `mem_rd_en`=0, `addr_sel_data`=1, `mem_addr`=`ex_addr` and `mem_wdata`=`ex_wdata`.
- R3: In every cycle in which a data access owns the port, `pc_we`=0 and `fd_bubble`=1.
- R4: In a cycle that follows no scheduled data access, the port is in fetch mode, with outputs as in R1.
- R5: With LOAD_STEALS=1, when `rf_issue`=1 with `rf_op`=2'b01 (load) and `flush`=0, the next cycle drives `mem_rd_en`=1, `mem_wr_en`=0, `addr_sel_data`=1, `mem_addr`=`ex_addr`, `mem_wdata`=0, `pc_we`=0 and `fd_bubble`=1.
- R6: With LOAD_STEALS=0, a load issue has no effect on the port: the next cycle is a fetch cycle.
- R7: `flush`=1 in the issue cycle cancels the scheduled access: the next cycle is a fetch cycle.
- R8: Memory operations issued in consecutive cycles each get their own data cycle, so fetch stays suppressed for as many consecutive cycles.
- R9: `mem_rd_en` and `mem_wr_en` are never both 1.
- R10: `rf_op` codes 2'b00 (no memory use) and 2'b11 (reserved) never take the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_issue | input | 1 | The register-read stage hands an instruction to execute at this edge |
| rf_op | input | 2 | Memory class of that instruction: 00 none, 01 load, 10 store, 11 reserved |
| flush | input | 1 | The instruction in the register-read stage is squashed this cycle |
| pc | input | AW | Current program counter |
| ex_addr | input | AW | Address operand of the instruction in execute |
| ex_wdata | input | DW | Data operand of the instruction in execute |
| mem_addr | output | AW | Address presented to the shared memory |
| mem_wdata | output | DW | Write data (zero unless storing) |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| addr_sel_data | output | 1 | 1 when the address comes from the data side |
| pc_we | output | 1 | Program counter may load its incremented value |
| fd_bubble | output | 1 | Fetch/decode register loads a bubble instead of a fetched word |

## Verification
The bench builds two copies with AW=6 and DW=8: one with LOAD_STEALS=1 and one with LOAD_STEALS=0. Both run on the same stimulus, so one run shows that a load either steals the port or leaves it alone. Narrow buses let the address and data follow arithmetic sequences that differ every cycle, so a wrong address-mux choice shows up at once. The swept 4-bit control combination walks through pairs of consecutive cycles. That covers the cases in which issue, flush, back-to-back memory operations and reserved codes meet.

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter bit LOAD_STEALS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rf_issue,
  input  logic [1:0]    rf_op,
  input  logic          flush,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ex_addr,
  input  logic [DW-1:0] ex_wdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic          addr_sel_data,
  output logic          pc_we,
  output logic          fd_bubble
);

  localparam logic [1:0] OP_LD = 2'b01;
  localparam logic [1:0] OP_ST = 2'b10;

  logic live_issue, want_st, want_ld;
  logic slot_st, slot_ld, data_slot;

  assign live_issue = rf_issue && !flush;
  assign want_st    = live_issue && (rf_op == OP_ST);

  generate
    if (LOAD_STEALS) begin : g_load_steals
      assign want_ld = live_issue && (rf_op == OP_LD);
    end else begin : g_load_waits
      assign want_ld = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_st <= 1'b0;
      slot_ld <= 1'b0;
    end else begin
      slot_st <= want_st;
      slot_ld <= want_ld;
    end
  end

  assign data_slot     = slot_st | slot_ld;
  assign addr_sel_data = data_slot;
  assign mem_addr      = data_slot ? ex_addr : pc;
  assign mem_wr_en     = slot_st;
  assign mem_rd_en     = !slot_st;
  assign mem_wdata     = slot_st ? ex_wdata : '0;
  assign pc_we         = !data_slot;
  assign fd_bubble     = data_slot;

  // R2
  store_takes_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_issue && !flush && rf_op == OP_ST) |=> (mem_wr_en && addr_sel_data));

  // R3
  fetch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel_data |-> (!pc_we && fd_bubble));

  // R4
  idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_issue |=> (pc_we && mem_rd_en && !mem_wr_en && !fd_bubble));

  // R5 R6
  load_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_issue && !flush && rf_op == OP_LD) |=> (addr_sel_data == LOAD_STEALS));

  // R7
  flush_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pc_we && !addr_sel_data));

  // R9
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

endmodule

// File: tb/mem_port_arbiter_test.sv
module mem_port_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_issue = 1'b0;
  logic [1:0] rf_op = 2'b00;
  logic flush = 1'b0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] ex_addr = '0;
  logic [DW-1:0] ex_wdata = '0;

  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wd, b_wd;
  logic a_rd, a_wr, a_sel, a_pcwe, a_bub;
  logic b_rd, b_wr, b_sel, b_pcwe, b_bub;

  int tests = 0;
  int fails = 0;
  bit exp_st = 1'b0, exp_ld = 1'b0, prev_slot = 1'b0, exp_flushed = 1'b0, exp_resv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_port_arbiter #(.AW(AW), .DW(DW), .LOAD_STEALS(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .rf_issue(rf_issue), .rf_op(rf_op), .flush(flush),
    .pc(pc), .ex_addr(ex_addr), .ex_wdata(ex_wdata),
    .mem_addr(a_addr), .mem_wdata(a_wd), .mem_rd_en(a_rd), .mem_wr_en(a_wr),
    .addr_sel_data(a_sel), .pc_we(a_pcwe), .fd_bubble(a_bub));

  mem_port_arbiter #(.AW(AW), .DW(DW), .LOAD_STEALS(1'b0)) uut_nl (
    .clk(clk), .rst_n(rst_n), .rf_issue(rf_issue), .rf_op(rf_op), .flush(flush),
    .pc(pc), .ex_addr(ex_addr), .ex_wdata(ex_wdata),
    .mem_addr(b_addr), .mem_wdata(b_wd), .mem_rd_en(b_rd), .mem_wr_en(b_wr),
    .addr_sel_data(b_sel), .pc_we(b_pcwe), .fd_bubble(b_bub));

  function automatic logic [AW+DW+4:0] expect_vec(bit st, bit ld);
    bit slot = st | ld;
    return {slot ? ex_addr : pc, st ? ex_wdata : {DW{1'b0}}, !st, st, slot, !slot, slot};
  endfunction

  task automatic check(string req, logic [AW+DW+4:0] act, logic [AW+DW+4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ports();
    string ra, rb;
    if (exp_resv) ra = "R10";
    else if (exp_flushed) ra = "R7";
    else if (exp_st && prev_slot) ra = "R8";
    else if (exp_st) ra = "R2 R3";
    else if (exp_ld) ra = "R5";
    else ra = "R4";
    rb = (exp_ld && !exp_flushed) ? "R6" : ra;
    check(ra, {a_addr, a_wd, a_rd, a_wr, a_sel, a_pcwe, a_bub}, expect_vec(exp_st, exp_ld));
    check(rb, {b_addr, b_wd, b_rd, b_wr, b_sel, b_pcwe, b_bub}, expect_vec(exp_st, 1'b0));
    check("R9", {{(AW+DW+3){1'b0}}, a_rd & a_wr, b_rd & b_wr}, '0);
  endtask

  task automatic step(bit iss, logic [1:0] op, bit fl, int s);
    @(negedge clk);
    check_ports();
    prev_slot   = exp_st | exp_ld;
    rf_issue    = iss;
    rf_op       = op;
    flush       = fl;
    pc          = AW'(s * 3);
    ex_addr     = AW'(s * 7 + 1);
    ex_wdata    = DW'(s * 11 + 5);
    exp_st      = iss && !fl && op == 2'b10;
    exp_ld      = iss && !fl && op == 2'b01;
    exp_flushed = iss && fl && op[1] != op[0];
    exp_resv    = iss && op == 2'b11;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    pc = 6'h2A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1", {a_addr, a_wd, a_rd, a_wr, a_sel, a_pcwe, a_bub}, expect_vec(1'b0, 1'b0));
    check("R1", {b_addr, b_wd, b_rd, b_wr, b_sel, b_pcwe, b_bub}, expect_vec(1'b0, 1'b0));
    rst_n = 1'b1;
    // R1 first cycle after reset
    step(1'b0, 2'b00, 1'b0, 1);
    // R2 R3 single store, R8 three stores in a row
    step(1'b1, 2'b10, 1'b0, 2);
    step(1'b0, 2'b00, 1'b0, 3);
    step(1'b1, 2'b10, 1'b0, 4);
    step(1'b1, 2'b10, 1'b0, 5);
    step(1'b1, 2'b10, 1'b0, 6);
    // R5 R6 load, R7 flushed store, R10 reserved code
    step(1'b1, 2'b01, 1'b0, 7);
    step(1'b1, 2'b10, 1'b1, 8);
    step(1'b1, 2'b11, 1'b0, 9);
    step(1'b0, 2'b10, 1'b0, 10);
    for (int s = 0; s < 1024; s++) begin
      int c = (s * 5 + s / 16) % 16;
      step(c[0], c[3:2], c[1] & s[5], s + 11);
    end
    step(1'b0, 2'b00, 1'b0, 2000);
    step(1'b0, 2'b00, 1'b0, 2001);
    finish_run();
  end
endmodule